// File: doc/BRIEF.md
# Complementary Output Pair with Encoded Dead Band

The block turns one pulse-width reference into a pair of complementary drive signals, a main output and a complement output. It guarantees that the two are never active together. Whenever the reference changes level, the output that must turn off does so at once. The output that must turn on waits a programmable number of clock cycles first. One clock cycle is one dead-time tick.

Each dead time is given as an 8-bit code. The code is decoded into a tick count through four ranges chosen by its top bits, and coarser steps buy a longer reach. A second code can set a separate dead time for falling edges of the reference. Both codes can also be held in shadow registers, so that new values take effect only when an update strobe arrives.

Top module: `dtb_deadband`

## Requirements
- R1: While reset is asserted, both outputs are low. After reset is released with the reference low, the complement output goes high on the first clock edge.
- R2: A code of 0 gives no delay. On every clock edge the main output takes the sampled reference and the complement output takes its inverse.
- R3: When code bit 7 is 0, the dead time is code[6:0] ticks. On the clock edge that samples a reference edge, the output that was active goes low. The other output goes high exactly that many edges later, provided the reference has not changed in the meantime.
- R4: When code[7:6] is 2'b10, the dead time is (64 + code[5:0]) x 2 ticks, which covers 128 to 254.
- R5: When code[7:5] is 3'b110, the dead time is (32 + code[4:0]) x 8 ticks, which covers 256 to 504.
- R6: When code[7:5] is 3'b111, the dead time is (32 + code[4:0]) x 16 ticks, which covers 512 to 1008.
- R7: When the asymmetric enable is 1, rising edges use the rise code and falling edges use the fall code. When it is 0, both edges use the rise code and the fall code has no effect.
- R8: If the reference returns to its old level before the dead time has elapsed, the delayed output never goes high for that pulse.
- R9: When the preload enable is 1, the codes in use are copied from the code inputs only on a clock edge where the update strobe is 1. Code changes made without a strobe do not affect any dead time.
- R10: When the preload enable is 0, the code inputs are used directly at each reference edge, and the update strobe has no effect.
- R11: The main and complement outputs are never high in the same cycle.
- R12: The dead time is fixed at the reference edge. A code change made while a dead time is counting does not shorten or lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one dead-time tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Pulse-width reference |
| dt_rise_i | input | 8 | Dead-time code for rising edges (and for both edges when asymmetric mode is off) |
| dt_fall_i | input | 8 | Dead-time code for falling edges in asymmetric mode |
| asym_en_i | input | 1 | 1 selects separate rise and fall dead times |
| preload_en_i | input | 1 | 1 makes the codes take effect only on an update strobe |
| update_i | input | 1 | Update strobe that copies the codes into the shadow registers |
| out_main_o | output | 1 | Main output; follows the reference high after the dead time |
| out_comp_o | output | 1 | Complement output; follows the reference low after the dead time |

## Verification
The bench checks one code from each decode range, plus the range edges 0x80 and 0xFF. A decoder that mixed up the range multipliers or offsets would shift the rising main output by tens or hundreds of cycles. Reference pulses shorter than the dead time are driven in both polarities. A design that let a stale counter expire would emit a sliver pulse here.

Shadow behaviour is checked by changing codes with no strobe. A design that let writes pass through would use the new delay. Separately, the code is changed while a dead time is counting. A counter that recomputed its target would end early. Asymmetric mode is checked in both settings, since a crossed select would apply the fall delay to both edges.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
    localparam int CODE_W    = 8;
    localparam int TICK_W    = 10;
    localparam int NUM_LANES = 2;
    localparam int LANE_RISE = 0;
    localparam int LANE_FALL = 1;
    localparam logic [TICK_W-1:0] MAX_TICKS = TICK_W'(1008);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        logic  ref_seen;
        tick_t cnt;
        logic  main;
        logic  comp;
    } chan_st_t;
endpackage

// File: rtl/dtb_decode.sv
module dtb_decode
    import dtb_pkg::*;
(
    input  code_t code_i,
    output tick_t ticks_o
);
    tick_t mant6;
    tick_t mant5;

    always_comb begin
        mant6 = {{(TICK_W-7){1'b0}}, 1'b1, code_i[5:0]};
        mant5 = {{(TICK_W-6){1'b0}}, 1'b1, code_i[4:0]};
        unique casez (code_i[CODE_W-1 -: 3])
            3'b0??:  ticks_o = {{(TICK_W-7){1'b0}}, code_i[6:0]};
            3'b10?:  ticks_o = mant6 << 1;
            3'b110:  ticks_o = mant5 << 3;
            default: ticks_o = mant5 << 4;
        endcase
    end
endmodule

// File: rtl/dtb_shadow.sv
module dtb_shadow
    import dtb_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  code_t code_i,
    input  logic  preload_en_i,
    input  logic  update_i,
    output code_t code_eff_o
);
    code_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (!preload_en_i || update_i) begin
            act_d = code_i;
        end
        code_eff_o = preload_en_i ? act_q : code_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) act_q <= '0;
        else         act_q <= act_d;
    end

    // R9
    shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preload_en_i && !update_i) |=> (act_q == $past(act_q)));
endmodule

// File: rtl/dtb_channel.sv
module dtb_channel
    import dtb_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  ref_i,
    input  tick_t rise_ticks_i,
    input  tick_t fall_ticks_i,
    output logic  main_o,
    output logic  comp_o
);
    chan_st_t s_d, s_q;
    logic     edge_seen;

    always_comb begin
        s_d       = s_q;
        s_d.ref_seen = ref_i;
        edge_seen = (ref_i != s_q.ref_seen);
        if (edge_seen) begin
            if (ref_i) begin
                s_d.comp = 1'b0;
                s_d.cnt  = rise_ticks_i;
                s_d.main = (rise_ticks_i == '0);
            end else begin
                s_d.main = 1'b0;
                s_d.cnt  = fall_ticks_i;
                s_d.comp = (fall_ticks_i == '0);
            end
        end else if (s_q.cnt > tick_t'(1)) begin
            s_d.cnt = s_q.cnt - tick_t'(1);
        end else begin
            s_d.cnt  = '0;
            s_d.main = s_q.ref_seen;
            s_d.comp = !s_q.ref_seen;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign main_o = s_q.main;
    assign comp_o = s_q.comp;

    // R11
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(main_o && comp_o));

    // R3
    edge_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_i && !s_q.ref_seen) |=> !comp_o);

    // R8
    main_follows_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        main_o |-> s_q.ref_seen);

    // R12
    dt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt > tick_t'(1) && ref_i == s_q.ref_seen) |=> ($stable(main_o) && $stable(comp_o)));

    // R6
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= MAX_TICKS);
endmodule

// File: rtl/dtb_deadband.sv
module dtb_deadband
    import dtb_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ref_i,
    input  logic [7:0] dt_rise_i,
    input  logic [7:0] dt_fall_i,
    input  logic       asym_en_i,
    input  logic       preload_en_i,
    input  logic       update_i,
    output logic       out_main_o,
    output logic       out_comp_o
);
    code_t code_in  [NUM_LANES];
    code_t code_eff [NUM_LANES];
    tick_t ticks    [NUM_LANES];
    tick_t fall_sel;

    assign code_in[LANE_RISE] = dt_rise_i;
    assign code_in[LANE_FALL] = dt_fall_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dtb_shadow u_shadow (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .code_i       (code_in[g]),
            .preload_en_i (preload_en_i),
            .update_i     (update_i),
            .code_eff_o   (code_eff[g])
        );
        dtb_decode u_decode (
            .code_i  (code_eff[g]),
            .ticks_o (ticks[g])
        );
    end

    assign fall_sel = asym_en_i ? ticks[LANE_FALL] : ticks[LANE_RISE];

    dtb_channel u_channel (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ref_i        (ref_i),
        .rise_ticks_i (ticks[LANE_RISE]),
        .fall_ticks_i (fall_sel),
        .main_o       (out_main_o),
        .comp_o       (out_comp_o)
    );

    // R1
    reset_low_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!out_main_o && !out_comp_o) || rst_ni);
endmodule

// File: tb/test_dtb_deadband.sv
`timescale 1ns/1ps
module test_dtb_deadband;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ref_i = 1'b0;
    logic [7:0] dt_rise = 8'd0;
    logic [7:0] dt_fall = 8'd0;
    logic       asym_en = 1'b0;
    logic       pre_en = 1'b0;
    logic       upd = 1'b0;
    logic       out_main, out_comp;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    typedef struct {
        bit    hi;
        bit    lo;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    dtb_deadband i_dtb_deadband (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .ref_i        (ref_i),
        .dt_rise_i    (dt_rise),
        .dt_fall_i    (dt_fall),
        .asym_en_i    (asym_en),
        .preload_en_i (pre_en),
        .update_i     (upd),
        .out_main_o   (out_main),
        .out_comp_o   (out_comp)
    );

    function automatic int ticks_of(input int code);
        if (code < 128)      return code;
        else if (code < 192) return 2 * (code - 64);
        else if (code < 224) return 8 * (code - 160);
        else                 return 16 * (code - 192);
    endfunction

    // reference model: runs on the sampling edge, pushes expectations
    bit m_ref = 1'b0;
    int m_run = 0;
    int m_dly = 0;
    int sh_rise = 0;
    int sh_fall = 0;
    always @(posedge clk) begin
        if (!rst_ni) begin
            m_ref = 1'b0; m_run = 0; m_dly = 0; sh_rise = 0; sh_fall = 0;
        end else begin
            int er, ef, dr, df;
            exp_t e;
            er = pre_en ? sh_rise : int'(dt_rise);
            ef = pre_en ? sh_fall : int'(dt_fall);
            dr = ticks_of(er);
            df = asym_en ? ticks_of(ef) : dr;
            if (ref_i != m_ref) begin
                m_ref = ref_i;
                m_run = 1;
                m_dly = ref_i ? dr : df;
            end else if (m_run < 5000) begin
                m_run++;
            end
            e.hi  = m_ref && (m_run > m_dly);
            e.lo  = !m_ref && (m_run > m_dly);
            e.tag = cur_tag;
            sb_q.push_back(e);
            if (!pre_en || upd) begin
                sh_rise = int'(dt_rise);
                sh_fall = int'(dt_fall);
            end
        end
    end

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (!rst_ni) begin
            checks++;
            if (out_main !== 1'b0 || out_comp !== 1'b0) begin
                errors++;
                $display("FAIL R1 reset: main=%b comp=%b expected 0 0", out_main, out_comp);
            end
        end else begin
            checks++;
            if (out_main === 1'b1 && out_comp === 1'b1) begin
                errors++;
                $display("FAIL R11 overlap: main=%b comp=%b expected not both 1", out_main, out_comp);
            end
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (out_main !== e.hi || out_comp !== e.lo) begin
                    errors++;
                    $display("FAIL %s at %0t: main=%b comp=%b expected %b %b",
                             e.tag, $time, out_main, out_comp, e.hi, e.lo);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int hi_len, input int lo_len);
        ref_i = 1'b1;
        wait_cyc(hi_len);
        ref_i = 1'b0;
        wait_cyc(lo_len);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        cur_tag = "R1";
        rst_ni = 1'b1;
        wait_cyc(3);

        cur_tag = "R2"; dt_rise = 8'd0;
        pulse(3, 3); pulse(1, 1); pulse(1, 2);

        cur_tag = "R3"; dt_rise = 8'd5;
        pulse(12, 12);
        dt_rise = 8'd127;
        pulse(140, 140);

        cur_tag = "R4"; dt_rise = 8'h85;
        pulse(150, 150);
        dt_rise = 8'h80;
        pulse(140, 140);

        cur_tag = "R5"; dt_rise = 8'hC3;
        pulse(300, 300);

        cur_tag = "R6"; dt_rise = 8'hFF;
        pulse(1020, 1020);
        dt_rise = 8'hE1;
        pulse(540, 540);

        cur_tag = "R7"; dt_rise = 8'd3; dt_fall = 8'd10; asym_en = 1'b1;
        pulse(20, 20);
        asym_en = 1'b0; dt_fall = 8'd50;
        pulse(20, 20);

        cur_tag = "R8"; dt_rise = 8'd20;
        pulse(5, 30); pulse(19, 30);
        ref_i = 1'b1; wait_cyc(30);
        ref_i = 1'b0; wait_cyc(6);
        ref_i = 1'b1; wait_cyc(30);
        ref_i = 1'b0; wait_cyc(30);

        cur_tag = "R9"; pre_en = 1'b1; dt_rise = 8'd4;
        upd = 1'b1; wait_cyc(1); upd = 1'b0;
        dt_rise = 8'd40;
        pulse(20, 20);
        upd = 1'b1; wait_cyc(1); upd = 1'b0;
        pulse(60, 60);

        cur_tag = "R10"; pre_en = 1'b0; dt_rise = 8'd7;
        upd = 1'b1;
        pulse(20, 20);
        upd = 1'b0; dt_rise = 8'd2;
        pulse(20, 20);

        cur_tag = "R12"; dt_rise = 8'd30;
        ref_i = 1'b1; wait_cyc(5);
        dt_rise = 8'd2; wait_cyc(45);
        ref_i = 1'b0; wait_cyc(40);

        wait_cyc(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule